// File: doc/BRIEF.md
# Shared Timer Tick Prescaler

This block divides the system clock into a single-cycle count-enable tick shared by several timers and a watchdog. A 4-bit rate value selects a division of rate + 1, so the tick can run anywhere from every clock down to once every 16 clocks. The rate is held in the block. It is loaded with a mode-dependent default during reset, and it can be rewritten at any time through a write strobe. A write restarts the divider.

The second timer has its own tick output. That output bypasses the divider and is high on every clock while the timer reports clock-out or baud generator operation. Six external pins pass through a two-flop synchronizer and are then captured into a sample register. The pins are the first timer input, the second timer input, the third timer input, the capture input and two interrupt inputs. In compatibility mode the sample register loads only on ticks. In fast mode it loads on every clock.

Top module: `tmr_tick_prescaler`

## Requirements
- R1: While no write occurs, `tick` is high for exactly one clock in every rate_o + 1 clocks. With rate_o = 0 it is high on every clock.
- R2: A clock edge with `rst_n` low and `fast_mode` low loads rate_o with 5, which gives one tick every 6 clocks.
- R3: A clock edge with `rst_n` low and `fast_mode` high loads rate_o with 0.
- R4: A clock edge with `rate_wr` high loads `rate_wdata` into rate_o and restarts the divider at zero. The first following tick is high in the clock cycle that begins at the rate_o-th edge after the write edge. For a new rate of 0 it is high in the cycle right after the write edge.
- R5: While `t2_clkout` or `t2_baudgen` is high (and reset is released), `t2_tick` is high on every clock, whatever the rate.
- R6: While both mode hints are low, `t2_tick` equals `tick`.
- R7: Each bit of `pin_in` passes through two synchronizer flops before it reaches the sample register. Bit order: 0 first timer input, 1 second timer input, 2 third timer input, 3 capture input, 4 interrupt 0, 5 interrupt 1.
- R8: With `fast_mode` low, `pin_smp` loads the synchronized pins only at an edge closing a cycle in which `tick` is high. At every other edge it holds its value.
- R9: With `fast_mode` high, `pin_smp` loads the synchronized pins at every edge.
- R10: While `rst_n` is low, `tick` and `t2_tick` are low. A reset edge clears `pin_smp` and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_mode | input | 1 | 1 = fast mode, 0 = compatibility mode |
| rate_wr | input | 1 | Write strobe for the rate value |
| rate_wdata | input | 4 | New rate value |
| t2_clkout | input | 1 | Second timer is in clock-out mode |
| t2_baudgen | input | 1 | Second timer is in baud generator mode |
| pin_in | input | 6 | Asynchronous external pins |
| rate_o | output | 4 | Current rate value |
| tick | output | 1 | Shared count-enable tick |
| t2_tick | output | 1 | Count enable for the second timer |
| pin_smp | output | 6 | Synchronized and sampled pins |

## Verification
`tick` and `t2_tick` are combinational from the divider state, so they are due in the same cycle as the state that produces them. A rate write shows on `rate_o` one edge later, and the tick following it comes rate_o edges after that. A pin change reaches `pin_smp` no sooner than the third edge, and only at an enabled edge. The bench runs a reference model that advances once per rising edge, using the inputs as they stand at that edge. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due. The run covers all 16 rates in both modes and applies each mode's reset default.

// File: rtl/tmr_tick_prescaler.sv
module tmr_tick_prescaler #(
  parameter int RATE_W      = 4,
  parameter int NPINS       = 6,
  parameter int COMPAT_RATE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_wdata,
  input  logic              t2_clkout,
  input  logic              t2_baudgen,
  input  logic [NPINS-1:0]  pin_in,
  output logic [RATE_W-1:0] rate_o,
  output logic              tick,
  output logic              t2_tick,
  output logic [NPINS-1:0]  pin_smp
);
  localparam logic [RATE_W-1:0] DFLT_COMPAT = RATE_W'(COMPAT_RATE);
  localparam logic [RATE_W-1:0] DFLT_FAST   = '0;

  logic [RATE_W-1:0] rate_q, cnt_q;
  logic [NPINS-1:0]  sync1_q, sync2_q, smp_q;
  logic              wrap, smp_en;

  assign wrap    = (cnt_q == rate_q);
  assign tick    = rst_n & wrap;
  assign t2_tick = rst_n & ((t2_clkout | t2_baudgen) | wrap);
  assign smp_en  = fast_mode | tick;
  assign rate_o  = rate_q;
  assign pin_smp = smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_q <= fast_mode ? DFLT_FAST : DFLT_COMPAT;
    else if (rate_wr) rate_q <= rate_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rate_wr || wrap) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      smp_q   <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (smp_en) smp_q <= sync2_q;
    end
  end
endmodule

// File: rtl/tmr_tick_prescaler_chk.sv
module tmr_tick_prescaler_chk #(
  parameter int RATE_W      = 4,
  parameter int NPINS       = 6,
  parameter int COMPAT_RATE = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fast_mode,
  input logic              rate_wr,
  input logic              t2_clkout,
  input logic              t2_baudgen,
  input logic [RATE_W-1:0] rate_o,
  input logic              tick,
  input logic              t2_tick,
  input logic [NPINS-1:0]  pin_smp
);
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rate_wr && rate_o != '0) |=> !tick);

  p_compat_default_r2: assert property (@(posedge clk)
    (!rst_n && !fast_mode) |=> rate_o == RATE_W'(COMPAT_RATE));

  p_fast_default_r3: assert property (@(posedge clk)
    (!rst_n && fast_mode) |=> rate_o == '0);

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_clkout || t2_baudgen) |-> t2_tick);

  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!t2_clkout && !t2_baudgen) |-> (t2_tick == tick));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_mode && !tick) |=> $stable(pin_smp));

  p_clear_r10: assert property (@(posedge clk)
    !rst_n |=> pin_smp == '0);
endmodule

bind tmr_tick_prescaler tmr_tick_prescaler_chk #(
  .RATE_W(RATE_W), .NPINS(NPINS), .COMPAT_RATE(COMPAT_RATE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .rate_wr(rate_wr),
  .t2_clkout(t2_clkout), .t2_baudgen(t2_baudgen), .rate_o(rate_o),
  .tick(tick), .t2_tick(t2_tick), .pin_smp(pin_smp)
);

// File: tb/tmr_tick_prescaler_tb_top.sv
module tmr_tick_prescaler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_mode = 1'b0;
  logic rate_wr = 1'b0;
  logic [3:0] rate_wdata = '0;
  logic t2_clkout = 1'b0, t2_baudgen = 1'b0;
  logic [5:0] pin_in = '0;
  logic [3:0] rate_o;
  logic tick, t2_tick;
  logic [5:0] pin_smp;

  int n_chk = 0, n_bad = 0;
  int m_rate = 5, m_phase = 0;
  logic [5:0] m_s1 = '0, m_s2 = '0, m_smp = '0;
  bit run_cmp = 0;

  always #2.5 clk = ~clk;

  tmr_tick_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .rate_wr(rate_wr),
    .rate_wdata(rate_wdata), .t2_clkout(t2_clkout), .t2_baudgen(t2_baudgen),
    .pin_in(pin_in), .rate_o(rate_o), .tick(tick), .t2_tick(t2_tick),
    .pin_smp(pin_smp)
  );

  function automatic bit exp_tick();
    return rst_n && ((m_phase % (m_rate + 1)) == m_rate);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate = fast_mode ? 0 : 5;
      m_phase = 0;
      m_s1 = '0; m_s2 = '0; m_smp = '0;
    end else begin
      if (fast_mode || exp_tick()) m_smp = m_s2;   // R8 R9
      m_s2 = m_s1;                                  // R7
      m_s1 = pin_in;
      if (rate_wr) begin m_rate = rate_wdata; m_phase = 0; end  // R4
      else m_phase++;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run_cmp) begin
    bit et;
    et = exp_tick();
    chk("R1/R4 tick", tick, et);
    chk((t2_clkout || t2_baudgen) ? "R5 t2_tick" : "R6 t2_tick", t2_tick,
        rst_n && (t2_clkout || t2_baudgen || et));
    chk("R2/R3/R4 rate_o", rate_o, m_rate);
    chk("R7/R8/R9 pin_smp", pin_smp, m_smp);
  end

  task automatic do_reset(bit fm);
    @(negedge clk); #1;
    rst_n = 1'b0; fast_mode = fm; rate_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 tick in reset", tick, 0);
    chk("R10 t2_tick in reset", t2_tick, 0);
    chk("R10 pin_smp cleared", pin_smp, 0);
    chk(fm ? "R3 fast default" : "R2 compat default", rate_o, fm ? 0 : 5);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rate_wr = 1'b0;
      pin_in = 6'($urandom);
      t2_clkout  = ($urandom % 5) == 0;
      t2_baudgen = ($urandom % 7) == 0;
    end
  endtask

  initial begin
    fork
      begin
        run_cmp = 1;
        for (int fm = 0; fm < 2; fm++) begin
          do_reset(fm[0]);
          run_cycles(30);     // default rate spacing
          for (int r = 0; r < 16; r++) begin
            @(negedge clk); #1;
            rate_wr = 1'b1; rate_wdata = 4'(r);
            run_cycles(50);
          end
          @(negedge clk); #1;
          fast_mode = ~fast_mode;   // mode switch affects sampling only
          run_cycles(40);
        end
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    run_cmp = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule